// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Aggregator

This block gathers the interrupt sources of a two-channel serial controller into one 8-bit status word. Each bit has a matching bit in a write-only enable mask, and the block drives a single interrupt request. Per channel it takes receiver-ready, FIFO-full and transmitter-ready levels, a break-detected level, a mode bit that picks the receive source, and a strobe that clears the break-change flag. A counter/timer ready level and a change-of-state level are shared by both channels.

Start and end of a break on a channel are turned into a sticky delta flag, which stays set until that channel's clear strobe. Software reads the raw status over a one-bit-address register bus and writes the mask there. The request is the registered OR of every status bit that is both set and enabled. The request is active-high; any pin inversion is done outside the block.

Top module: `serial_irq_aggregator`

## Requirements
- R1: Status bit positions, MSB to LSB: 7 change-of-state, 6 delta-break B, 5 receive B, 4 transmit-ready B, 3 counter/timer ready, 2 delta-break A, 1 receive A, 0 transmit-ready A. Channel A is index 0 of each per-channel port and channel B is index 1. The status is read at bus address 0.
- R2: The mask is written from `bus_wdata` by a write at bus address 1 and uses the status bit positions. It cannot be read back, so reads at address 1 return zero. It resets to all zeros.
- R3: `irq` is a register that takes the OR of (status AND mask), so it follows a status or mask change one clock later.
- R4: A status read returns the unmasked bits whatever the mask holds.
- R5: A channel's delta-break bit becomes 1 one clock after its break level changes, whether the break starts (0 to 1) or ends (1 to 0).
- R6: A delta-break bit holds at 1 until that channel's clear strobe is sampled high, and then reads 0. A clear strobe on one channel leaves the other channel's flag unchanged.
- R7: A clear strobe sampled in the same clock as a new break-level change leaves the flag at 1.
- R8: A channel's receive bit shows its FIFO-full level when its mode bit is 1, and its receiver-ready level when the mode bit is 0.
- R9: The transmit-ready, counter/timer and change-of-state bits follow their input levels in the same cycle, with no latching.
- R10: Reset clears the mask, the delta-break flags, the break-level history and `irq`.
- R11: A write at bus address 0 changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_rdy | input | 2 | Receiver-ready level per channel |
| rx_full | input | 2 | Receive FIFO-full level per channel |
| tx_rdy | input | 2 | Transmitter-ready level per channel |
| brk_lvl | input | 2 | Break-detected level per channel |
| rx_sel_full | input | 2 | Receive source mode per channel (1 = FIFO full) |
| brk_clr | input | 2 | Delta-break clear strobe per channel |
| ct_rdy | input | 1 | Counter/timer ready level |
| cos_evt | input | 1 | Change-of-state level |
| bus_addr | input | 1 | Register address (0 status, 1 mask) |
| bus_wr | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
A table of mask and level patterns first sets every level source with the mask cleared, which shows that reads are unmasked. Each source is then enabled alone, and also masked off while it is active, so a wrong bit position or a leaking mask bit shows up. The receive source is tried with both mode settings and opposite ready and full levels, which shows which flag feeds each channel. Directed sequences cover break start, hold, clear, break end, a clear on the other channel, a clear in the same clock as a new transition, writes at the status address and the reset state.

// File: rtl/sia_pkg.sv
// Package: shared constants for the serial interrupt aggregator.
// Assumes exactly two channels whose status nibbles sit four bits apart.
package sia_pkg;
    localparam int NUM_CH    = 2;
    localparam int STAT_W    = 8;
    localparam int ADDR_W    = 1;
    localparam int CH_STRIDE = STAT_W / NUM_CH;
    localparam int TX_OFS    = 0;
    localparam int RX_OFS    = 1;
    localparam int DBRK_OFS  = 2;
    localparam int CT_BIT    = 3;
    localparam int COS_BIT   = 7;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 1'b1;
endpackage

// File: rtl/sia_break_tracker.sv
// Module: tracks one channel's break level and raises a sticky delta flag
// on every change of that level. Assumes brk_lvl is already synchronous to clk.
// A new change has priority over the clear strobe in the same cycle.
module sia_break_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_lvl,
    input  logic clr,
    output logic delta
);
    logic lvl_q;
    logic delta_q;
    logic change;

    // Purpose: detect a break start or end against last cycle's level.
    always_comb begin
        change = brk_lvl ^ lvl_q;
    end

    // Purpose: keep level history and the sticky delta flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            delta_q <= 1'b0;
        end else begin
            lvl_q <= brk_lvl;
            if (change) begin
                delta_q <= 1'b1;
            end else if (clr) begin
                delta_q <= 1'b0;
            end
        end
    end

    assign delta = delta_q;
endmodule

// File: rtl/sia_rx_select.sv
// Module: picks a channel's receive status source from its mode bit.
// Purely combinational; assumes both source levels are synchronous.
module sia_rx_select (
    input  logic sel_full,
    input  logic rdy,
    input  logic full,
    output logic rx_stat
);
    // Purpose: choose FIFO-full when the mode bit is set, ready otherwise.
    always_comb begin
        rx_stat = sel_full ? full : rdy;
    end
endmodule

// File: rtl/sia_mask_irq.sv
// Module: holds the write-only enable mask and registers the request.
// Assumes wr_en is already qualified with the mask address.
module sia_mask_irq
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    logic [STAT_W-1:0] mask_q;
    logic              irq_q;

    // Purpose: load the enable mask on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wdata;
        end
    end

    // Purpose: register the OR of enabled, active status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & mask_q);
        end
    end

    assign mask = mask_q;
    assign irq  = irq_q;
endmodule

// File: rtl/serial_irq_aggregator.sv
// Module: top of the dual-channel serial interrupt aggregator. Builds the
// 8-bit status word, serves the register bus and drives the request.
// Assumes all inputs are synchronous to clk; the request is active high.
module serial_irq_aggregator
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_rdy,
    input  logic [NUM_CH-1:0] rx_full,
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] brk_lvl,
    input  logic [NUM_CH-1:0] rx_sel_full,
    input  logic [NUM_CH-1:0] brk_clr,
    input  logic              ct_rdy,
    input  logic              cos_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq
);
    logic [STAT_W-1:0] status_w;
    logic [STAT_W-1:0] mask_q;
    logic [NUM_CH-1:0] delta_w;
    logic [NUM_CH-1:0] rx_w;
    logic              mask_wr;

    // Purpose: per-channel break tracking, receive select and bit placement.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sia_break_tracker u_brk (
            .clk    (clk),
            .rst_n  (rst_n),
            .brk_lvl(brk_lvl[c]),
            .clr    (brk_clr[c]),
            .delta  (delta_w[c])
        );

        sia_rx_select u_rx (
            .sel_full(rx_sel_full[c]),
            .rdy     (rx_rdy[c]),
            .full    (rx_full[c]),
            .rx_stat (rx_w[c])
        );

        assign status_w[c*CH_STRIDE + TX_OFS]   = tx_rdy[c];
        assign status_w[c*CH_STRIDE + RX_OFS]   = rx_w[c];
        assign status_w[c*CH_STRIDE + DBRK_OFS] = delta_w[c];
    end

    // Purpose: shared sources pass straight through to their bits.
    assign status_w[CT_BIT]  = ct_rdy;
    assign status_w[COS_BIT] = cos_evt;

    // Purpose: qualify mask writes by address.
    assign mask_wr = bus_wr && (bus_addr == ADDR_MASK);

    sia_mask_irq u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_wr),
        .wdata (bus_wdata),
        .status(status_w),
        .mask  (mask_q),
        .irq   (irq)
    );

    // Purpose: status reads are raw; the mask address reads as zero.
    always_comb begin
        bus_rdata = (bus_addr == ADDR_STATUS) ? status_w : '0;
    end
endmodule

// File: rtl/sia_checker.sv
// Module: property checker for the aggregator, attached by bind.
module sia_checker
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_rdy,
    input  logic [NUM_CH-1:0] rx_full,
    input  logic [NUM_CH-1:0] rx_sel_full,
    input  logic [NUM_CH-1:0] brk_lvl,
    input  logic [NUM_CH-1:0] brk_clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic [STAT_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic              irq
);
    // R3
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == |($past(status & mask))));

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_MASK) |=> (mask == $past(bus_wdata)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int DB = c*CH_STRIDE + DBRK_OFS;
        localparam int RX = c*CH_STRIDE + RX_OFS;

        // R5 and R7: a level change sets the flag even with a clear present
        dbrk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && brk_lvl[c] != $past(brk_lvl[c])) |=> status[DB]);

        // R6
        dbrk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status[DB] && !brk_clr[c]) |=> status[DB]);

        // R6
        dbrk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && brk_clr[c] && brk_lvl[c] == $past(brk_lvl[c]))
            |=> !status[DB]);

        // R8
        rx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_STATUS)
            |-> (bus_rdata[RX] == (rx_sel_full[c] ? rx_full[c] : rx_rdy[c])));
    end
endmodule

bind serial_irq_aggregator sia_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_rdy     (rx_rdy),
    .rx_full    (rx_full),
    .rx_sel_full(rx_sel_full),
    .brk_lvl    (brk_lvl),
    .brk_clr    (brk_clr),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .status     (status_w),
    .mask       (mask_q),
    .irq        (irq)
);

// File: tb/tb_serial_irq_aggregator.sv
module tb_serial_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rx_rdy, rx_full, tx_rdy, brk_lvl, rx_sel_full, brk_clr;
    logic       ct_rdy, cos_evt;
    logic [0:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .rx_rdy(rx_rdy), .rx_full(rx_full),
        .tx_rdy(tx_rdy), .brk_lvl(brk_lvl), .rx_sel_full(rx_sel_full),
        .brk_clr(brk_clr), .ct_rdy(ct_rdy), .cos_evt(cos_evt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] mask;
        logic       cos;
        logic       ct;
        logic [1:0] rxr;
        logic [1:0] full;
        logic [1:0] txr;
        logic [1:0] sel;
        logic [7:0] stat;
        logic       irq;
    } vec_t;

    // mask, cos, ct, rx_rdy{B,A}, rx_full{B,A}, tx_rdy{B,A}, sel{B,A}, status, irq
    localparam vec_t VECS [10] = '{
        '{8'h00, 1'b1, 1'b1, 2'b11, 2'b00, 2'b11, 2'b00, 8'hBB, 1'b0},
        '{8'h80, 1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 8'h80, 1'b1},
        '{8'h7F, 1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 8'h80, 1'b0},
        '{8'h02, 1'b0, 1'b0, 2'b01, 2'b00, 2'b00, 2'b01, 8'h00, 1'b0},
        '{8'h02, 1'b0, 1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 8'h02, 1'b1},
        '{8'h20, 1'b0, 1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 8'h20, 1'b1},
        '{8'h20, 1'b0, 1'b0, 2'b10, 2'b00, 2'b00, 2'b10, 8'h00, 1'b0},
        '{8'h10, 1'b0, 1'b0, 2'b00, 2'b00, 2'b10, 2'b00, 8'h10, 1'b1},
        '{8'h01, 1'b0, 1'b0, 2'b00, 2'b00, 2'b10, 2'b00, 8'h10, 1'b0},
        '{8'h08, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 8'h08, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic addr, input logic [7:0] data);
        bus_addr = addr; bus_wr = 1'b1; bus_wdata = data;
        tick();
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic idle_inputs();
        rx_rdy = '0; rx_full = '0; tx_rdy = '0; brk_lvl = '0;
        rx_sel_full = '0; brk_clr = '0; ct_rdy = 1'b0; cos_evt = 1'b0;
        bus_addr = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        check("R10 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        check("R10 status after reset", bus_rdata, 8'h00);
        check("R10 irq after reset", {7'd0, irq}, 8'h00);

        // table: R1 R2 R3 R4 R8 R9
        for (int i = 0; i < 10; i++) begin
            cos_evt = VECS[i].cos; ct_rdy = VECS[i].ct; rx_rdy = VECS[i].rxr;
            rx_full = VECS[i].full; tx_rdy = VECS[i].txr; rx_sel_full = VECS[i].sel;
            write_reg(1'b1, VECS[i].mask);
            tick();
            check($sformatf("R1/R4/R8/R9 status vec %0d", i), bus_rdata, VECS[i].stat);
            check($sformatf("R3 irq vec %0d", i), {7'd0, irq}, {7'd0, VECS[i].irq});
        end

        // break handling
        idle_inputs();
        write_reg(1'b1, 8'h44);
        tick();
        brk_lvl[0] = 1'b1;
        tick();
        check("R5 break start sets A", bus_rdata, 8'h04);
        check("R3 irq not yet", {7'd0, irq}, 8'h00);
        tick();
        check("R3 irq one clock later", {7'd0, irq}, 8'h01);
        repeat (3) tick();
        check("R6 flag sticky", bus_rdata, 8'h04);
        brk_clr[0] = 1'b1;
        tick();
        brk_clr[0] = 1'b0;
        check("R6 clear A", bus_rdata, 8'h00);
        brk_lvl[0] = 1'b0;
        tick();
        check("R5 break end sets A", bus_rdata, 8'h04);
        brk_lvl[1] = 1'b1; brk_clr[0] = 1'b1;
        tick();
        brk_clr[0] = 1'b0;
        check("R6 clear A leaves B, R5 sets B", bus_rdata, 8'h40);
        brk_clr[1] = 1'b1; brk_lvl[1] = 1'b0;
        tick();
        brk_clr[1] = 1'b0;
        check("R7 clear with new change keeps B", bus_rdata, 8'h40);
        brk_clr[1] = 1'b1;
        tick();
        brk_clr[1] = 1'b0;
        check("R6 clear B", bus_rdata, 8'h00);

        // R11: status address write is ignored
        write_reg(1'b0, 8'hFF);
        tx_rdy[0] = 1'b1;
        tick();
        check("R11 status write ignored", bus_rdata, 8'h01);
        check("R11 mask unchanged, irq off", {7'd0, irq}, 8'h00);
        bus_addr = 1'b1;
        #1;
        check("R2 mask address reads zero", bus_rdata, 8'h00);
        bus_addr = 1'b0;

        // R10: reset clears flags and mask
        tx_rdy[0] = 1'b0;
        brk_lvl[0] = 1'b1;
        tick();
        brk_lvl[0] = 1'b0;
        tick();
        check("R5 flag set before reset", bus_rdata, 8'h04);
        rst_n = 1'b0;
        cos_evt = 1'b1; ct_rdy = 1'b1;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (2) tick();
        check("R10 flags cleared, raw bits shown", bus_rdata, 8'h88);
        check("R10 mask cleared, irq off", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule